// File: doc/BRIEF.md
# Option Register Write-Protection Filter

This block guards a small bank of flash control and option registers that two CPUs share over one register bus. Each bus write carries the issuing CPU, a secure attribute and a privileged attribute. For every write the block decides, in the same cycle, whether to commit it or to drop it. The decision depends on the register's protection class, on a global security-enable input and on a privilege-mode input. Reads are never filtered.

A dropped write leaves every register bit as it was and sets a sticky illegal-access flag. An interrupt line reports the flag when its enable bit is set. Inside the option register the upper half holds secure fields and the lower half holds non-secure fields. A write that would change a secure field needs stronger rights than a write that changes only non-secure fields. If any part of such a write is refused, the whole write is dropped.

Address map: 0 open control, 1 guard control, 2 status, 3 option, 4 write-protect, 5 security attribute, 6 boot vector, 7 unmapped. The CPU select `cpuId` is 0 for CPU1 and 1 for CPU2. The term "locked" below means `secEn`=1 and `privModeEn`=1.

Top module: `optprot_filter`

## Requirements
- R1: Writes to address 0 (open control) and address 2 (status) are always committed, whatever the CPU and attributes.
- R2: A write to address 1 (guard control) is committed only when it is both secure and privileged, whatever `secEn` and `privModeEn` are.
- R3: A write to address 4 (write-protect) must be privileged when locked. When `secEn`=0, `privModeEn` is ignored and every write commits.
- R4: When locked, every write to address 3 (option) must be privileged. A write that changes any bit in the secure field mask (default bits 31:16) must also come from CPU2 and be secure. CPU1 can never change those bits while locked.
- R5: A refused write to the option register is discarded in full, so its non-secure bits are not updated either.
- R6: Writes to addresses 5 and 6 must be secure when `secEn`=1, and they must also be privileged when locked.
- R7: `rdData` always returns the stored contents of `addr`, whatever the access attributes.
- R8: A committed write updates its register at the next clock edge. A refused write changes no register bit and sets the illegal-access flag at the next edge.
- R9: Status bit 0 is the sticky flag, cleared by writing 1 to it. Status bit 1 is the interrupt enable. `irq` is high exactly when both bits are set.
- R10: Address 7 reads as zero. Writes to it have no effect and never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secEn | input | 1 | Global security enable |
| privModeEn | input | 1 | Privilege-mode protection enable |
| wrEn | input | 1 | Write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 32 | Write data |
| cpuId | input | 1 | Issuing CPU: 0 = CPU1, 1 = CPU2 |
| attrSec | input | 1 | Secure attribute of the access |
| attrPriv | input | 1 | Privileged attribute of the access |
| rdData | output | 32 | Read data for `addr` |
| irq | output | 1 | Illegal-access interrupt |

## Verification
The bench sweeps every address against all 32 combinations of security enable, privilege mode, CPU, secure and privileged attributes. For the option register it uses three write patterns: secure bits only, non-secure bits only, and both. This is the case most likely to go wrong. A filter that accepts only the non-secure half, or that tests the CPU but not the secure attribute, produces a readback that differs from the arithmetic model. The bench also checks that `privModeEn` has no effect when `secEn`=0, which a design that gates on `privModeEn` alone would break. It checks that the flag survives disabling the interrupt and survives writing 0 to its bit, which a level-type flag or a write-to-clear-anything flag would get wrong.

// File: rtl/optprot_pkg.sv
package optprot_pkg;

  typedef enum logic [2:0] {
    PC_NONE,
    PC_OPEN,
    PC_ALWAYS_SP,
    PC_PRIV,
    PC_SEC_PRIV,
    PC_OPTION
  } protClass_e;

  localparam int A_ACCESS  = 0;
  localparam int A_GUARD   = 1;
  localparam int A_STATUS  = 2;
  localparam int A_OPTION  = 3;
  localparam int A_WRPROT  = 4;
  localparam int A_SECATTR = 5;
  localparam int A_BOOTVEC = 6;

  typedef struct packed {
    logic commit;
    logic reject;
  } wrStrobe_t;

  function automatic protClass_e classOf(input int a);
    case (a)
      A_ACCESS, A_STATUS:   classOf = PC_OPEN;
      A_GUARD:              classOf = PC_ALWAYS_SP;
      A_OPTION:             classOf = PC_OPTION;
      A_WRPROT:             classOf = PC_PRIV;
      A_SECATTR, A_BOOTVEC: classOf = PC_SEC_PRIV;
      default:              classOf = PC_NONE;
    endcase
  endfunction

  function automatic logic isStorage(input int a);
    isStorage = (classOf(a) != PC_NONE) && (a != A_STATUS);
  endfunction

endpackage

// File: rtl/optprot_ctrl.sv
module optprot_ctrl
  import optprot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] SEC_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secEn,
  input  logic              privModeEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cpuId,
  input  logic              attrSec,
  input  logic              attrPriv,
  input  logic [DATA_W-1:0] optCur,
  output wrStrobe_t         stb
);

  logic       locked;
  logic       secChange;
  logic       allow;
  protClass_e cls;

  always_comb begin
    locked    = secEn & privModeEn;
    cls       = classOf(int'(addr));
    secChange = |((wrData ^ optCur) & SEC_MASK);
    case (cls)
      PC_OPEN:      allow = 1'b1;
      PC_ALWAYS_SP: allow = attrSec & attrPriv;
      PC_PRIV:      allow = !locked | attrPriv;
      PC_SEC_PRIV:  allow = (!secEn | attrSec) & (!locked | attrPriv);
      PC_OPTION:    allow = !locked |
                            (attrPriv & (!secChange | (cpuId & attrSec)));
      default:      allow = 1'b0;
    endcase
    stb.commit = wrEn & (cls != PC_NONE) & allow;
    stb.reject = wrEn & (cls != PC_NONE) & !allow;
  end

  // R3: with security off, the privilege-mode input must not block the write-protect register
  assert_privmode_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !secEn && int'(addr) == A_WRPROT) |-> stb.commit);

  // R4: CPU1 changing secure option bits while locked is refused
  assert_cpu1_secure_refused_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !cpuId && secEn && privModeEn && int'(addr) == A_OPTION &&
     ((wrData ^ optCur) & SEC_MASK) != '0) |-> stb.reject);

  // R2: the guard register refuses anything not secure and privileged
  assert_guard_needs_sp_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) == A_GUARD && !(attrSec && attrPriv)) |-> !stb.commit);

  // R8: commit and reject never occur together
  assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.commit && stb.reject));

endmodule

// File: rtl/optprot_regs.sv
module optprot_regs
  import optprot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] optCur,
  output logic              irq
);

  localparam int NUM_SLOTS = 1 << ADDR_W;

  logic [NUM_SLOTS-1:0][DATA_W-1:0] slotRd;
  logic flagQ;
  logic irqEnQ;
  logic statusWr;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    if (isStorage(i)) begin : gStore
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                q <= '0;
        else if (stb.commit && int'(addr) == i)   q <= wrData;
      end
      assign slotRd[i] = q;
    end else begin : gEmpty
      assign slotRd[i] = '0;
    end
  end

  assign statusWr = stb.commit && int'(addr) == A_STATUS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      irqEnQ <= 1'b0;
    end else begin
      if (stb.reject)                flagQ <= 1'b1;
      else if (statusWr && wrData[0]) flagQ <= 1'b0;
      if (statusWr) irqEnQ <= wrData[1];
    end
  end

  always_comb begin
    if (int'(addr) == A_STATUS) begin
      rdData    = '0;
      rdData[0] = flagQ;
      rdData[1] = irqEnQ;
    end else begin
      rdData = slotRd[addr];
    end
  end

  assign optCur = slotRd[A_OPTION];
  assign irq    = flagQ & irqEnQ;

  // R8: a refused write leaves every stored register unchanged
  assert_reject_keeps_regs_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.reject |=> $stable(slotRd));

  // R8: a refused write raises the flag at the next edge
  assert_reject_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.reject |=> flagQ);

  // R9: the flag stays set unless a status write with bit 0 set clears it
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !(statusWr && wrData[0])) |=> flagQ);

  // R10: the unmapped slot always reads zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    slotRd[NUM_SLOTS-1] == '0);

endmodule

// File: rtl/optprot_filter.sv
module optprot_filter
  import optprot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] SEC_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secEn,
  input  logic              privModeEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cpuId,
  input  logic              attrSec,
  input  logic              attrPriv,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  wrStrobe_t         stb;
  logic [DATA_W-1:0] optCur;

  optprot_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_MASK(SEC_MASK)) uCtrl (
    .clk(clk), .rstN(rstN), .secEn(secEn), .privModeEn(privModeEn),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .cpuId(cpuId),
    .attrSec(attrSec), .attrPriv(attrPriv), .optCur(optCur), .stb(stb)
  );

  optprot_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .optCur(optCur), .irq(irq)
  );

endmodule

// File: tb/tb_optprot_filter.sv
`timescale 1ns/1ps
module tb_optprot_filter;

  localparam logic [31:0] SM = 32'hFFFF_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, secEn, privModeEn, wrEn, cpuId, attrSec, attrPriv, irq;
  logic [2:0]  addr;
  logic [31:0] wrData, rdData;

  optprot_filter dut (
    .clk(clk), .rstN(rstN), .secEn(secEn), .privModeEn(privModeEn),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .cpuId(cpuId),
    .attrSec(attrSec), .attrPriv(attrPriv), .rdData(rdData), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] model [8];
  bit mFlag = 0;
  bit mEn = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input int a);
    case (a)
      0: reqOf = "R1";
      1: reqOf = "R2";
      2: reqOf = "R1";
      3: reqOf = "R4/R5";
      4: reqOf = "R3";
      5, 6: reqOf = "R6";
      default: reqOf = "R10";
    endcase
  endfunction

  function automatic bit expAllow(input int a, input logic [31:0] d,
                                  input bit se, input bit pm, input bit cpu,
                                  input bit s, input bit p);
    bit lk = se & pm;
    case (a)
      0, 2: expAllow = 1;
      1:    expAllow = s & p;
      3:    expAllow = !lk || (p && ((((d ^ model[3]) & SM) == 0) || (cpu && s)));
      4:    expAllow = !lk || p;
      5, 6: expAllow = (!se || s) && (!lk || p);
      default: expAllow = 0;
    endcase
  endfunction

  task automatic busWrite(input int a, input logic [31:0] d,
                          input bit se, input bit pm, input bit cpu,
                          input bit s, input bit p);
    bit ok = expAllow(a, d, se, pm, cpu, s, p);
    @(negedge clk);
    addr = 3'(a); wrData = d; secEn = se; privModeEn = pm;
    cpuId = cpu; attrSec = s; attrPriv = p; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (a != 7) begin
      if (ok) begin
        if (a == 2) begin
          mEn = d[1];
          if (d[0]) mFlag = 0;
        end else model[a] = d;
      end else mFlag = 1;
    end
  endtask

  task automatic readChk(input int a, input string req);
    logic [31:0] exp;
    addr = 3'(a);
    #1;
    if (a == 2) exp = {30'b0, mEn, mFlag};
    else if (a == 7) exp = '0;
    else exp = model[a];
    chk(req, rdData, exp);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    rstN = 0; secEn = 0; privModeEn = 0; wrEn = 0; cpuId = 0;
    attrSec = 0; attrPriv = 0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // Reset state
    for (int a = 0; a < 8; a++) readChk(a, "R8 reset");
    chk("R9 reset irq", 32'(irq), 32'd0);

    busWrite(2, 32'h2, 0, 0, 0, 0, 0);
    readChk(2, "R9 enable");

    // Sweep every address over all attribute and mode combinations
    for (int a = 0; a < 8; a++) begin
      if (a == 2) continue;
      for (int c = 0; c < 32; c++) begin
        for (int k = 0; k < 3; k++) begin
          logic [31:0] d;
          if (a == 3) d = model[3] ^ ((k == 0) ? SM : (k == 1) ? ~SM : 32'hFFFF_FFFF);
          else if (k == 0) d = model[a] ^ 32'hA5A5_5A5A ^ 32'(c);
          else continue;
          busWrite(a, d, c[4], c[3], c[2], c[1], c[0]);
          readChk(a, reqOf(a));
          readChk(2, "R8 flag");
          chk("R9 irq", 32'(irq), 32'(mFlag & mEn));
          if (mFlag) begin
            busWrite(2, 32'h3, 0, 0, 0, 0, 0);
            readChk(2, "R9 clear");
          end
        end
      end
    end

    // R4/R5: CPU1 locked, privileged, mixed write: nothing changes
    busWrite(3, 32'h1111_2222, 0, 0, 0, 0, 0);
    busWrite(3, 32'hAAAA_BBBB, 1, 1, 0, 1, 1);
    readChk(3, "R5 mixed refused");
    busWrite(3, 32'h1111_3333, 1, 1, 0, 0, 1);
    readChk(3, "R4 cpu1 non-secure ok");
    busWrite(2, 32'h3, 0, 0, 0, 0, 0);

    // R9: flag survives disable and a zero write to bit 0
    busWrite(1, 32'h5, 0, 0, 1, 0, 1);
    busWrite(2, 32'h0, 0, 0, 0, 0, 0);
    readChk(2, "R9 disabled flag kept");
    chk("R9 irq masked", 32'(irq), 32'd0);
    busWrite(2, 32'h2, 0, 0, 0, 0, 0);
    chk("R9 irq unmasked", 32'(irq), 32'd1);
    busWrite(2, 32'h3, 0, 0, 0, 0, 0);
    readChk(2, "R9 cleared");
    chk("R9 irq cleared", 32'(irq), 32'd0);

    // R7: reads ignore attributes
    for (int a = 0; a < 8; a++) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        cpuId = c[2]; attrSec = c[1]; attrPriv = c[0];
        readChk(a, "R7");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule